// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block runs one memory block operation for an 8-bit processor core once the instruction has been decoded. It copies bytes from a source pointer to a destination pointer, or it compares the accumulator against bytes at a pointer. Either form can run as a single step or can repeat until it reaches a terminal condition. The pointers move up or down as selected. A 16-bit count register is decremented once per byte.

A decoder pulses `start` with the operation kind, direction and repeat selection. At the same moment it presents the pointer, count, accumulator and flag values. The sequencer then works through a byte-wide memory port that has a ready handshake. It writes back the updated pointers, count and flags, and pulses `done`. It also reports the instruction-cycle cost and the refresh-counter advance for the operation, so that the core can keep its own accounting.

A repeating operation can be paused by `stopReq` at the end of any iteration that is not its last. The block then reports `rewind`, which tells the core to move its program counter back by two so that the instruction runs again later from the saved registers.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `memReq`, `memWe` and `rewind` are 0, and `cycleCount` is 0.
- R2: In a copy step, the byte read at the source pointer is written to the destination pointer. Both pointers then move by +1 when `stepDown`=0, or by −1 when `stepDown`=1, and the count drops by one.
- R3: Copy flags use these bit positions: 7 sign, 6 zero, 5 and 3 undocumented, 4 half-carry, 2 parity/overflow, 1 subtract, 0 carry. Bits 7, 6 and 0 are kept. Bits 4 and 1 are cleared. Bit 2 is set when the decremented count is nonzero. With n = (byte + accumulator) mod 256, bit 3 is n[3] and bit 5 is n[1].
- R4: In a search step (`opKind`=1), d = accumulator − byte (mod 256). The source pointer moves and the count drops by one, while the destination pointer and memory are left untouched. Bit 7 is d[7] and bit 6 is (d==0). Bit 4 is the borrow out of the low nibble, bit 1 is 1, and bit 0 is kept. Bit 2 is set when the count is nonzero. With m = d − bit4, bit 5 is m[1] and bit 3 is m[3].
- R5: A repeating copy runs until the count reaches zero, so it moves exactly the starting count of bytes.
- R6: A repeating search stops after the first iteration in which the count reaches zero or d is zero.
- R7: `cycleCount` adds 21 for each iteration that continues and 16 for the final iteration. A single step therefore costs 16.
- R8: `refreshAdv` adds 2 for every iteration, including single steps.
- R9: If `stopReq` is high at the end of a repeating iteration that is not final, the operation ends. `rewind` is then 1, flag bit 2 is 1, that iteration costs 21, and the registers show the iterations already completed. On a final iteration, `stopReq` has no effect.
- R10: While `memReq` is high and `memReady` is low, the block holds its state: `memReq`, `memWe`, `memAddr` and the register outputs stay unchanged.
- R11: `done` is a one-cycle pulse with `busy` low. It appears in the cycle after the final write-back, and the outputs are already updated in that cycle. A `start` pulse while `busy` is ignored.
- R12: `memReq` is high only while `busy` is high. `memWe` is high only together with `memReq`, and only during the write of a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opKind | input | 1 | 0 copy, 1 search |
| stepDown | input | 1 | 1 moves pointers downward |
| repeatOp | input | 1 | 1 repeats until terminal condition |
| stopReq | input | 1 | Pause request for a repeating operation |
| hlIn | input | 16 | Source pointer at start |
| deIn | input | 16 | Destination pointer at start |
| bcIn | input | 16 | Byte count at start |
| accIn | input | 8 | Accumulator |
| flagsIn | input | 8 | Flags at start |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with memReady |
| memReady | input | 1 | Access completes this cycle |
| hlOut | output | 16 | Source pointer |
| deOut | output | 16 | Destination pointer |
| bcOut | output | 16 | Byte count |
| flagsOut | output | 8 | Result flags |
| cycleCount | output | 32 | Instruction-cycle cost of the operation |
| refreshAdv | output | 8 | Refresh-counter advance |
| rewind | output | 1 | Operation paused; re-execute the instruction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
The properties assume that `memRdata` holds valid data in every cycle in which a read is requested and `memReady` is high. They also assume that reset is applied before the first `start`. No property depends on how long `memReady` stays low. The bench memory model returns data from a 256-byte array whenever it is addressed. The bench keeps every pointer and count small enough that no operation wraps an address. It holds `memReady` low for several cycles in the middle of an operation, and it raises `start` during that stall only to show that the pulse is ignored.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  localparam int DATA_W = 8;

  // flag bit positions (fixed by the core's flag register layout)
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;

  localparam logic [DATA_W-1:0] COPY_KEEP   = 8'hC1; // S, Z, C kept
  localparam logic [DATA_W-1:0] SEARCH_KEEP = 8'h01; // C kept
  localparam logic [DATA_W-1:0] HALF_MASK   = 8'h10;

  typedef enum logic [0:0] {
    OP_COPY   = 1'b0,
    OP_SEARCH = 1'b1
  } opKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_UPDATE
  } seqState_e;

  typedef struct packed {
    logic load;     // capture operands at start
    logic capture;  // latch read byte
    logic commit;   // write back one iteration
    logic lastStep; // iteration is the final one
    logic pause;    // iteration ends early on stop request
  } seqStrobe_t;

  // undocumented bits: bit 5 from v[1], bit 3 from v[3]
  function automatic logic [DATA_W-1:0] yxBits(input logic [DATA_W-1:0] v);
    return ((v << 4) & 8'h20) | (v & 8'h08);
  endfunction

endpackage

// File: rtl/blk_seq_ctrl.sv
module blk_seq_ctrl
  import blkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  opKind_e    opKind,
  input  logic       stopReq,
  input  logic       memReady,
  input  logic       lastIter,
  output seqStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);

  seqState_e state, stateNext;
  opKind_e   kindReg;

  always_comb begin
    stateNext = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.capture = 1'b1;
          stateNext    = (kindReg == OP_SEARCH) ? ST_UPDATE : ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) stateNext = ST_UPDATE;
      end
      ST_UPDATE: begin
        strb.commit = 1'b1;
        if (lastIter) begin
          strb.lastStep = 1'b1;
          stateNext     = ST_IDLE;
        end else if (stopReq) begin
          strb.pause = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          stateNext = ST_READ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= OP_COPY;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.commit & (strb.lastStep | strb.pause);
      if (strb.load) kindReg <= opKind;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/blk_seq_dp.sv
module blk_seq_dp
  import blkseq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CYC_W        = 32,
  parameter int CONT_COST    = 21,
  parameter int FINAL_COST   = 16,
  parameter int REFRESH_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              writePhase,
  input  opKind_e           opKind,
  input  logic              stepDown,
  input  logic              repeatOp,
  input  logic [ADDR_W-1:0] hlIn,
  input  logic [ADDR_W-1:0] deIn,
  input  logic [ADDR_W-1:0] bcIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] flagsIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              lastIter,
  output logic [ADDR_W-1:0] hlOut,
  output logic [ADDR_W-1:0] deOut,
  output logic [ADDR_W-1:0] bcOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic [CYC_W-1:0]  cycleCount,
  output logic [7:0]        refreshAdv,
  output logic              rewind
);

  localparam logic [CYC_W-1:0]  CONT_ADD  = CYC_W'(CONT_COST);
  localparam logic [CYC_W-1:0]  FINAL_ADD = CYC_W'(FINAL_COST);
  localparam logic [7:0]        REF_ADD   = 8'(REFRESH_STEP);
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

  logic [ADDR_W-1:0] hl, de, bc;
  logic [DATA_W-1:0] acc, flags, byteReg;
  logic              down, rep;
  opKind_e           kind;

  logic [ADDR_W-1:0] hlNext, deNext, bcNext;
  logic [DATA_W-1:0] diff, adjusted, sumN, copyFlags, searchFlags, newFlags;
  logic              bcNz, halfBorrow, match;

  always_comb begin
    hlNext     = down ? hl - ONE : hl + ONE;
    deNext     = down ? de - ONE : de + ONE;
    bcNext     = bc - ONE;
    bcNz       = |bcNext;
    diff       = acc - byteReg;
    match      = (diff == '0);
    halfBorrow = |((acc ^ byteReg ^ diff) & HALF_MASK);
    adjusted   = diff - DATA_W'(halfBorrow);
    sumN       = byteReg + acc;

    copyFlags = (flags & COPY_KEEP) | yxBits(sumN);
    copyFlags[FLAG_PV] = bcNz;

    searchFlags = (flags & SEARCH_KEEP) | yxBits(adjusted);
    searchFlags[FLAG_S]  = diff[DATA_W-1];
    searchFlags[FLAG_Z]  = match;
    searchFlags[4]       = halfBorrow;
    searchFlags[FLAG_PV] = bcNz;
    searchFlags[FLAG_N]  = 1'b1;

    newFlags = (kind == OP_SEARCH) ? searchFlags : copyFlags;
    if (strb.pause) newFlags[FLAG_PV] = 1'b1;

    lastIter = !rep || !bcNz || ((kind == OP_SEARCH) && match);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hl         <= '0;
      de         <= '0;
      bc         <= '0;
      acc        <= '0;
      flags      <= '0;
      byteReg    <= '0;
      down       <= 1'b0;
      rep        <= 1'b0;
      kind       <= OP_COPY;
      cycleCount <= '0;
      refreshAdv <= '0;
      rewind     <= 1'b0;
    end else begin
      if (strb.load) begin
        hl         <= hlIn;
        de         <= deIn;
        bc         <= bcIn;
        acc        <= accIn;
        flags      <= flagsIn;
        down       <= stepDown;
        rep        <= repeatOp;
        kind       <= opKind;
        cycleCount <= '0;
        refreshAdv <= '0;
        rewind     <= 1'b0;
      end
      if (strb.capture) byteReg <= memRdata;
      if (strb.commit) begin
        hl         <= hlNext;
        bc         <= bcNext;
        flags      <= newFlags;
        cycleCount <= cycleCount + (strb.lastStep ? FINAL_ADD : CONT_ADD);
        refreshAdv <= refreshAdv + REF_ADD;
        rewind     <= strb.pause;
        if (kind == OP_COPY) de <= deNext;
      end
    end
  end

  assign memAddr  = writePhase ? de : hl;
  assign memWdata = byteReg;
  assign hlOut    = hl;
  assign deOut    = de;
  assign bcOut    = bc;
  assign flagsOut = flags;

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blkseq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CYC_W        = 32,
  parameter int CONT_COST    = 21,
  parameter int FINAL_COST   = 16,
  parameter int REFRESH_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opKind,
  input  logic              stepDown,
  input  logic              repeatOp,
  input  logic              stopReq,
  input  logic [ADDR_W-1:0] hlIn,
  input  logic [ADDR_W-1:0] deIn,
  input  logic [ADDR_W-1:0] bcIn,
  input  logic [7:0]        accIn,
  input  logic [7:0]        flagsIn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memReady,
  output logic [ADDR_W-1:0] hlOut,
  output logic [ADDR_W-1:0] deOut,
  output logic [ADDR_W-1:0] bcOut,
  output logic [7:0]        flagsOut,
  output logic [CYC_W-1:0]  cycleCount,
  output logic [7:0]        refreshAdv,
  output logic              rewind,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strb;
  logic       lastIter;
  opKind_e    kindIn;

  assign kindIn = opKind_e'(opKind);

  blk_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opKind   (kindIn),
    .stopReq  (stopReq),
    .memReady (memReady),
    .lastIter (lastIter),
    .strb     (strb),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .done     (done)
  );

  blk_seq_dp #(
    .ADDR_W       (ADDR_W),
    .CYC_W        (CYC_W),
    .CONT_COST    (CONT_COST),
    .FINAL_COST   (FINAL_COST),
    .REFRESH_STEP (REFRESH_STEP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .writePhase (memWe),
    .opKind     (kindIn),
    .stepDown   (stepDown),
    .repeatOp   (repeatOp),
    .hlIn       (hlIn),
    .deIn       (deIn),
    .bcIn       (bcIn),
    .accIn      (accIn),
    .flagsIn    (flagsIn),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .lastIter   (lastIter),
    .hlOut      (hlOut),
    .deOut      (deOut),
    .bcOut      (bcOut),
    .flagsOut   (flagsOut),
    .cycleCount (cycleCount),
    .refreshAdv (refreshAdv),
    .rewind     (rewind)
  );

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W     = 16,
  parameter int CYC_W      = 32,
  parameter int FINAL_COST = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] hlOut,
  input logic [7:0]        flagsOut,
  input logic [CYC_W-1:0]  cycleCount,
  input logic              rewind,
  input logic              busy,
  input logic              done
);

  // R12
  we_with_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R12
  req_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(hlOut)));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  rewind_pv_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rewind) |-> flagsOut[2]);

  // R7
  done_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycleCount >= CYC_W'(FINAL_COST)));

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
  .ADDR_W     (ADDR_W),
  .CYC_W      (CYC_W),
  .FINAL_COST (FINAL_COST)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memWe      (memWe),
  .memReady   (memReady),
  .memAddr    (memAddr),
  .hlOut      (hlOut),
  .flagsOut   (flagsOut),
  .cycleCount (cycleCount),
  .rewind     (rewind),
  .busy       (busy),
  .done       (done)
);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;

  typedef struct packed {
    logic        kind;
    logic        down;
    logic [15:0] hl;
    logic [15:0] de;
    logic [15:0] bc;
    logic [7:0]  acc;
    logic [7:0]  flg;
    logic [7:0]  data;
    logic [15:0] expHl;
    logic [15:0] expDe;
    logic [15:0] expBc;
    logic [7:0]  expFlg;
  } vec_t;

  // single-step vectors, expected values worked out from R2, R3, R4
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 16'h0010, 16'h0080, 16'h0003, 8'h20, 8'hD3, 8'h05, 16'h0011, 16'h0081, 16'h0002, 8'hC5},
    '{1'b0, 1'b1, 16'h0020, 16'h0090, 16'h0001, 8'h03, 8'h00, 8'h07, 16'h001F, 16'h008F, 16'h0000, 8'h28},
    '{1'b1, 1'b0, 16'h0030, 16'h1234, 16'h0005, 8'h10, 8'h01, 8'h01, 16'h0031, 16'h1234, 16'h0004, 8'h3F},
    '{1'b1, 1'b1, 16'h0040, 16'h0055, 16'h0001, 8'h42, 8'h00, 8'h42, 16'h003F, 16'h0055, 16'h0000, 8'h42},
    '{1'b1, 1'b0, 16'h0050, 16'h0066, 16'h0002, 8'h20, 8'h00, 8'h30, 16'h0051, 16'h0066, 16'h0001, 8'h86}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        start, opKind, stepDown, repeatOp, stopReq;
  logic [15:0] hlIn, deIn, bcIn;
  logic [7:0]  accIn, flagsIn;
  logic        memReq, memWe, memReady;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic [15:0] hlOut, deOut, bcOut;
  logic [7:0]  flagsOut, refreshAdv;
  logic [31:0] cycleCount;
  logic        rewind, busy, done;

  logic [7:0]  mem [256];
  logic        pokeEn;
  logic [7:0]  pokeA, pokeD;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_xfer_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .stepDown(stepDown),
    .repeatOp(repeatOp), .stopReq(stopReq), .hlIn(hlIn), .deIn(deIn), .bcIn(bcIn),
    .accIn(accIn), .flagsIn(flagsIn), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .hlOut(hlOut), .deOut(deOut), .bcOut(bcOut), .flagsOut(flagsOut),
    .cycleCount(cycleCount), .refreshAdv(refreshAdv), .rewind(rewind),
    .busy(busy), .done(done)
  );

  assign memRdata = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (pokeEn) mem[pokeA] <= pokeD;
    else if (memReq && memWe && memReady) mem[memAddr[7:0]] <= memWdata;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    pokeEn = 1'b1; pokeA = a; pokeD = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic launch(input logic k, input logic dn, input logic rp,
                        input logic [15:0] hl, input logic [15:0] de, input logic [15:0] bc,
                        input logic [7:0] a, input logic [7:0] f);
    opKind = k; stepDown = dn; repeatOp = rp;
    hlIn = hl; deIn = de; bcIn = bc; accIn = a; flagsIn = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    for (int i = 0; i < 5000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    checks = checks + 1;
    failures = failures + 1;
    $display("FAIL %s actual=no_done expected=done", tag);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; opKind = 1'b0; stepDown = 1'b0; repeatOp = 1'b0;
    stopReq = 1'b0; hlIn = '0; deIn = '0; bcIn = '0; accIn = '0; flagsIn = '0;
    memReady = 1'b1; pokeEn = 1'b0; pokeA = '0; pokeD = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 memReq", memReq, 0);
    check("R1 memWe", memWe, 0);
    check("R1 rewind", rewind, 0);
    check("R1 cycleCount", cycleCount, 0);
    rstN = 1'b1;
    @(negedge clk);

    // single-step vector table: R2 R3 R4 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      poke(VECS[v].hl[7:0], VECS[v].data);
      poke(VECS[v].de[7:0], 8'hEE);
      launch(VECS[v].kind, VECS[v].down, 1'b0, VECS[v].hl, VECS[v].de, VECS[v].bc,
             VECS[v].acc, VECS[v].flg);
      waitDone("R11 vector done");
      check(VECS[v].kind ? "R4 hl" : "R2 hl", hlOut, VECS[v].expHl);
      check(VECS[v].kind ? "R4 de" : "R2 de", deOut, VECS[v].expDe);
      check(VECS[v].kind ? "R4 bc" : "R2 bc", bcOut, VECS[v].expBc);
      check(VECS[v].kind ? "R4 flags" : "R3 flags", flagsOut, VECS[v].expFlg);
      check(VECS[v].kind ? "R4 no write" : "R2 written byte", mem[VECS[v].de[7:0]],
            VECS[v].kind ? 8'hEE : VECS[v].data);
      check("R7 single cost", cycleCount, 16);
      check("R8 single refresh", refreshAdv, 2);
      check("R9 no rewind", rewind, 0);
      @(negedge clk);
      check("R11 done pulse width", done, 0);
    end

    // R5 repeating copy of four bytes upward
    for (int i = 0; i < 4; i++) begin
      poke(8'h60 + 8'(i), 8'h11 * 8'(i + 1));
      poke(8'hA0 + 8'(i), 8'h00);
    end
    launch(1'b0, 1'b0, 1'b1, 16'h0060, 16'h00A0, 16'h0004, 8'h00, 8'h00);
    waitDone("R5 done");
    for (int i = 0; i < 4; i++)
      check("R5 copied byte", mem[8'hA0 + 8'(i)], 8'h11 * 8'(i + 1));
    check("R5 hl", hlOut, 16'h0064);
    check("R5 de", deOut, 16'h00A4);
    check("R5 bc", bcOut, 16'h0000);
    check("R5 flags", flagsOut, 8'h00);
    check("R7 repeat cost", cycleCount, 79);
    check("R8 repeat refresh", refreshAdv, 8);
    @(negedge clk);

    // R6 repeating search that hits a match on the third byte
    poke(8'h70, 8'h01); poke(8'h71, 8'h02); poke(8'h72, 8'h33); poke(8'h73, 8'h33);
    launch(1'b1, 1'b0, 1'b1, 16'h0070, 16'h0000, 16'h000A, 8'h33, 8'h01);
    waitDone("R6 match done");
    check("R6 match hl", hlOut, 16'h0073);
    check("R6 match bc", bcOut, 16'h0007);
    check("R6 match flags", flagsOut, 8'h47);
    check("R7 match cost", cycleCount, 58);
    check("R8 match refresh", refreshAdv, 6);
    @(negedge clk);

    // R6 repeating search that runs out of count
    poke(8'h80, 8'h00); poke(8'h81, 8'h00); poke(8'h82, 8'h10);
    launch(1'b1, 1'b0, 1'b1, 16'h0080, 16'h0000, 16'h0003, 8'hFF, 8'h00);
    waitDone("R6 count done");
    check("R6 count hl", hlOut, 16'h0083);
    check("R6 count bc", bcOut, 16'h0000);
    check("R6 count flags", flagsOut, 8'hAA);
    check("R7 count cost", cycleCount, 58);
    @(negedge clk);

    // R9 pause of a repeating copy after its first iteration
    poke(8'h90, 8'h08);
    stopReq = 1'b1;
    launch(1'b0, 1'b0, 1'b1, 16'h0090, 16'h00C0, 16'h0005, 8'h00, 8'h00);
    waitDone("R9 pause done");
    check("R9 rewind", rewind, 1);
    check("R9 hl", hlOut, 16'h0091);
    check("R9 de", deOut, 16'h00C1);
    check("R9 bc", bcOut, 16'h0004);
    check("R9 flags", flagsOut, 8'h0C);
    check("R9 cost", cycleCount, 21);
    check("R9 byte", mem[8'hC0], 8'h08);
    @(negedge clk);

    // R9 stop request on a final iteration has no effect
    launch(1'b0, 1'b0, 1'b1, 16'h0090, 16'h00C8, 16'h0001, 8'h00, 8'h00);
    waitDone("R9 final done");
    check("R9 final rewind", rewind, 0);
    check("R9 final cost", cycleCount, 16);
    check("R9 final flags", flagsOut, 8'h08);
    stopReq = 1'b0;
    @(negedge clk);

    // R10 stall and R11 start ignored while busy
    poke(8'hB0, 8'h5A);
    poke(8'hD0, 8'h00);
    memReady = 1'b0;
    launch(1'b0, 1'b0, 1'b0, 16'h00B0, 16'h00D0, 16'h0002, 8'h00, 8'h00);
    for (int i = 0; i < 5; i++) begin
      check("R10 req held", memReq, 1);
      check("R10 addr held", memAddr, 16'h00B0);
      check("R12 no write on read", memWe, 0);
      check("R10 hl held", hlOut, 16'h00B0);
      @(negedge clk);
    end
    launch(1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0009, 8'h00, 8'h00);
    check("R11 busy while stalled", busy, 1);
    memReady = 1'b1;
    waitDone("R10 done");
    check("R11 start ignored hl", hlOut, 16'h00B1);
    check("R11 start ignored de", deOut, 16'h00D1);
    check("R11 start ignored bc", bcOut, 16'h0001);
    check("R10 byte", mem[8'hD0], 8'h5A);
    check("R3 stalled flags", flagsOut, 8'h2C);
    check("R11 busy low at done", busy, 0);
    @(negedge clk);
    check("R11 idle after", busy, 0);
    check("R12 req idle", memReq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule